// File: doc/BRIEF.md
# Interrupt Trigger Sensing Unit

This unit sits in front of the masking controllers of an interrupt subsystem. It takes a set of raw interrupt wires, 64 by default, and turns each one into a clean request line. Every input first passes through a two-flop synchronizer. After that, each line is judged under its own trigger mode: rising edge, falling edge, level-high or level-low. The lines are grouped into banks of 32, and every bank has an identical window of eight word registers on a small 32-bit, byte-addressed read/write port.

Two independent configuration bits per line, named "rise" and "fall", select the trigger mode. Software never writes these bits directly. Instead, each bit vector has a set register and a clear register, so one line can be reprogrammed without a read-modify-write sequence. In an edge mode, a detected edge is captured in a sticky raw-event bit that stays set until software acknowledges it with a write-one-to-clear. In a level mode, the request simply follows the synchronized input, inverted when the line is level-low. The 64 request outputs are registered.

Top module: `irq_trig_sense`

## Requirements
- R1: After reset, all rise and fall bits, all raw-event bits and all request outputs are 0, so every line starts as level-high.
- R2: Byte address bit 5 selects the bank (offset 0x20 is the high bank, lines 32 to 63). Bits 4:2 select the register within the bank. Read data is registered and is valid on the clock edge that samples the read strobe.
- R3: Writes to offset 0x10 set, and writes to 0x14 clear, the rise bits at the positions written as 1. Offsets 0x18 and 0x1C do the same for the fall bits. All other bits are unchanged. The rise and fall bits read back at 0x08 and 0x0C.
- R4: The {rise,fall} pair selects the mode: 10 is rising edge, 01 is falling edge, 00 is level-high and 11 is level-low.
- R5: In an edge mode, the selected edge of the synchronized input sets the line's raw-event bit, and the bit holds until it is acknowledged. The opposite edge, and any activity in a level mode, never sets it.
- R6: Writing to offset 0x04 clears the raw-event bits written as 1 and leaves the bits written as 0 alone. Writing all ones clears every pending event in the bank.
- R7: If a new edge is detected in the same cycle as an acknowledge of that bit, the raw-event bit stays set.
- R8: The request for an edge-mode line equals its raw-event bit. A level-high line follows its synchronized input, and a level-low line follows the inverse of that input.
- R9: Offset 0x00 reads the bank's request outputs. Writes to 0x00, 0x08 and 0x0C have no effect.
- R10: A level-mode request changes on the 3rd rising clock edge after an input change. An edge-mode request rises on the 4th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Raw asynchronous interrupt wires |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | BANK_W | Write data |
| reg_rdata | output | BANK_W | Registered read data |
| irq_req | output | N_LINES | Registered conditioned request lines |

## Verification
Request latency has two fixed values. A change on an input reaches the synchronizer output after two edges, and a level-mode request follows one edge later, on the 3rd edge. An edge-mode request first needs a raw-event capture, so it appears on the 4th edge. The latency test drives inputs at a falling clock edge and checks the request at every following falling edge, so it sees the exact edge on which each output changes. The other tests wait a fixed settle period longer than either latency before they check. The collision test aligns an acknowledge write with the edge that captures a new event, which tests the edge-wins rule on its only relevant cycle. Register reads are checked at the falling edge after the sampling rising edge.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

  // Word index inside a bank window (byte address bits 4:2).
  typedef enum logic [2:0] {
    IDX_STATUS   = 3'd0,
    IDX_RAW      = 3'd1,
    IDX_RISE     = 3'd2,
    IDX_FALL     = 3'd3,
    IDX_RISE_SET = 3'd4,
    IDX_RISE_CLR = 3'd5,
    IDX_FALL_SET = 3'd6,
    IDX_FALL_CLR = 3'd7
  } reg_idx_e;

  localparam int unsigned IDX_W = 3;

endpackage

// File: rtl/irq_trig_sync.sv
module irq_trig_sync #(
  parameter int unsigned W      = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage[s] <= '0;
      end else if (s == 0) begin
        stage[s] <= d;
      end else begin
        stage[s] <= stage[(s == 0) ? 0 : s - 1];
      end
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/irq_trig_bank.sv
module irq_trig_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sync_in,
  input  logic [W-1:0] rise_set,
  input  logic [W-1:0] rise_clr,
  input  logic [W-1:0] fall_set,
  input  logic [W-1:0] fall_clr,
  input  logic [W-1:0] ack,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q,
  output logic [W-1:0] raw_q,
  output logic [W-1:0] edge_hit,
  output logic [W-1:0] req_q
);

  logic [W-1:0] prev_q;
  logic [W-1:0] rise_ev, fall_ev;
  logic [W-1:0] edge_mode, cond;

  always_comb begin
    rise_ev   = sync_in & ~prev_q;
    fall_ev   = ~sync_in & prev_q;
    edge_mode = rise_q ^ fall_q;
    // {rise,fall}: 10 rising, 01 falling
    edge_hit  = (rise_ev & rise_q & ~fall_q) | (fall_ev & ~rise_q & fall_q);
    // level: invert when both bits are set (level-low)
    cond      = (edge_mode & raw_q) | (~edge_mode & (sync_in ^ (rise_q & fall_q)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
      raw_q  <= '0;
      prev_q <= '0;
      req_q  <= '0;
    end else begin
      rise_q <= (rise_q | rise_set) & ~rise_clr;
      fall_q <= (fall_q | fall_set) & ~fall_clr;
      prev_q <= sync_in;
      raw_q  <= (raw_q & ~ack) | edge_hit;   // new edge beats acknowledge
      req_q  <= cond;
    end
  end

endmodule

// File: rtl/irq_trig_sense.sv
module irq_trig_sense
  import irq_trig_pkg::*;
#(
  parameter int unsigned N_LINES     = 64,
  parameter int unsigned BANK_W      = 32,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [BANK_W-1:0]  reg_wdata,
  output logic [BANK_W-1:0]  reg_rdata,
  output logic [N_LINES-1:0] irq_req
);

  localparam int unsigned N_BANKS    = N_LINES / BANK_W;
  localparam int unsigned BANK_SEL_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1;
  localparam int unsigned BANK_LSB   = 2 + IDX_W;

  logic [N_LINES-1:0]    sync_q;
  logic [N_LINES-1:0]    all_rise, all_fall, all_raw, all_edge;
  logic [BANK_SEL_W-1:0] bank_idx;
  reg_idx_e              reg_idx;
  logic [1:0]            unused_byte_lane;

  assign bank_idx         = reg_addr[BANK_LSB +: BANK_SEL_W];
  assign reg_idx          = reg_idx_e'(reg_addr[2 +: IDX_W]);
  assign unused_byte_lane = reg_addr[1:0];

  irq_trig_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_in),
    .q   (sync_q)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic              hit;
    logic [BANK_W-1:0] m_rs, m_rc, m_fs, m_fc, m_ack;

    always_comb begin
      hit   = reg_wr && (bank_idx == BANK_SEL_W'(b));
      m_rs  = (hit && reg_idx == IDX_RISE_SET) ? reg_wdata : '0;
      m_rc  = (hit && reg_idx == IDX_RISE_CLR) ? reg_wdata : '0;
      m_fs  = (hit && reg_idx == IDX_FALL_SET) ? reg_wdata : '0;
      m_fc  = (hit && reg_idx == IDX_FALL_CLR) ? reg_wdata : '0;
      m_ack = (hit && reg_idx == IDX_RAW)      ? reg_wdata : '0;
    end

    irq_trig_bank #(.W(BANK_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .sync_in  (sync_q[b*BANK_W +: BANK_W]),
      .rise_set (m_rs),
      .rise_clr (m_rc),
      .fall_set (m_fs),
      .fall_clr (m_fc),
      .ack      (m_ack),
      .rise_q   (all_rise[b*BANK_W +: BANK_W]),
      .fall_q   (all_fall[b*BANK_W +: BANK_W]),
      .raw_q    (all_raw[b*BANK_W +: BANK_W]),
      .edge_hit (all_edge[b*BANK_W +: BANK_W]),
      .req_q    (irq_req[b*BANK_W +: BANK_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_idx)
        IDX_STATUS: reg_rdata <= irq_req[bank_idx*BANK_W +: BANK_W];
        IDX_RAW:    reg_rdata <= all_raw[bank_idx*BANK_W +: BANK_W];
        IDX_RISE:   reg_rdata <= all_rise[bank_idx*BANK_W +: BANK_W];
        IDX_FALL:   reg_rdata <= all_fall[bank_idx*BANK_W +: BANK_W];
        default:    reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_trig_sense_chk.sv
module irq_trig_sense_chk #(
  parameter int unsigned N_LINES = 64,
  parameter int unsigned ADDR_W  = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [N_LINES-1:0] rise_cfg,
  input logic [N_LINES-1:0] fall_cfg,
  input logic [N_LINES-1:0] raw_q,
  input logic [N_LINES-1:0] sync_q,
  input logic [N_LINES-1:0] edge_hit,
  input logic [N_LINES-1:0] irq_req
);

  logic armed;
  logic cfg_wr, ack_wr;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assign cfg_wr = reg_wr && reg_addr[4];
  assign ack_wr = reg_wr && (reg_addr[4:2] == 3'd1);

  a_r3_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    (armed && !cfg_wr) |=> ($stable(rise_cfg) && $stable(fall_cfg)));

  a_r6_raw_sticky: assert property (@(posedge clk) disable iff (rst)
    (armed && !ack_wr) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

  a_r7_edge_wins: assert property (@(posedge clk) disable iff (rst)
    armed |=> ((raw_q & $past(edge_hit)) == $past(edge_hit)));

  a_r5_no_level_latch: assert property (@(posedge clk) disable iff (rst)
    armed |=> ((raw_q & ~$past(raw_q) & ~$past(rise_cfg ^ fall_cfg)) == '0));

  a_r8_level_high: assert property (@(posedge clk) disable iff (rst)
    armed |=> (((irq_req ^ $past(sync_q)) & $past(~rise_cfg & ~fall_cfg)) == '0));

  a_r8_level_low: assert property (@(posedge clk) disable iff (rst)
    armed |=> (((irq_req ^ ~$past(sync_q)) & $past(rise_cfg & fall_cfg)) == '0));

endmodule

bind irq_trig_sense irq_trig_sense_chk #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .rise_cfg (all_rise),
  .fall_cfg (all_fall),
  .raw_q    (all_raw),
  .sync_q   (sync_q),
  .edge_hit (all_edge),
  .irq_req  (irq_req)
);

// File: tb/sim_irq_trig_sense.sv
`timescale 1ns/1ps
module sim_irq_trig_sense;

  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] irq_in;
  logic        reg_wr, reg_rd;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [63:0] irq_req;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  irq_trig_sense u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic cleanup();
    wr(6'h14, 32'hFFFF_FFFF); wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h34, 32'hFFFF_FFFF); wr(6'h3C, 32'hFFFF_FFFF);
    irq_in = '0;
    settle();
    wr(6'h04, 32'hFFFF_FFFF); wr(6'h24, 32'hFFFF_FFFF);
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 request after reset", irq_req, 64'h0);
    rd(6'h08, d); chk("R1 rise cfg reset", 64'(d), 64'h0);
    rd(6'h0C, d); chk("R1 fall cfg reset", 64'(d), 64'h0);
    rd(6'h04, d); chk("R1 raw reset", 64'(d), 64'h0);
    @(negedge clk); irq_in[5] = 1'b1;
    settle();
    chk("R1 default level-high", 64'(irq_req[5]), 64'h1);
    irq_in = '0; settle();
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(6'h10, 32'h0000_00F0); rd(6'h08, d); chk("R3 rise set", 64'(d), 64'hF0);
    wr(6'h10, 32'h0000_0300); rd(6'h08, d); chk("R3 rise set keeps", 64'(d), 64'h3F0);
    wr(6'h14, 32'h0000_0030); rd(6'h08, d); chk("R3 rise clear", 64'(d), 64'h3C0);
    wr(6'h18, 32'h0000_00A5); rd(6'h0C, d); chk("R3 fall set", 64'(d), 64'hA5);
    wr(6'h1C, 32'h0000_0005); rd(6'h0C, d); chk("R3 fall clear", 64'(d), 64'hA0);
    wr(6'h08, 32'hFFFF_FFFF); wr(6'h0C, 32'h0000_0000); wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h08, d); chk("R9 rise cfg write ignored", 64'(d), 64'h3C0);
    rd(6'h0C, d); chk("R9 fall cfg write ignored", 64'(d), 64'hA0);
    cleanup();
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(6'h10, 32'h8); wr(6'h18, 32'h8);       // line 3 level-low, line 2 level-high
    settle();
    chk("R8 level-low idle asserted", 64'(irq_req[3:2]), 64'h2);
    rd(6'h00, d); chk("R9 status reads requests", 64'(d[3:2]), 64'h2);
    @(negedge clk); irq_in[3:2] = 2'b11;
    @(posedge clk); @(negedge clk); chk("R10 level edge1", 64'(irq_req[3:2]), 64'h2);
    @(posedge clk); @(negedge clk); chk("R10 level edge2", 64'(irq_req[3:2]), 64'h2);
    @(posedge clk); @(negedge clk); chk("R10 level edge3", 64'(irq_req[3:2]), 64'h1);
    rd(6'h04, d); chk("R5 level no latch", 64'(d), 64'h0);
    cleanup();
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wr(6'h10, 32'h80); settle();
    @(negedge clk); irq_in[7] = 1'b1;
    for (int e = 1; e <= 3; e++) begin
      @(posedge clk); @(negedge clk);
      chk("R10 edge before 4th", 64'(irq_req[7]), 64'h0);
    end
    @(posedge clk); @(negedge clk); chk("R10 edge at 4th", 64'(irq_req[7]), 64'h1);
    irq_in[7] = 1'b0; settle();
    chk("R5 rise sticky", 64'(irq_req[7]), 64'h1);
    rd(6'h04, d); chk("R5 raw captured", 64'(d), 64'h80);
    wr(6'h04, 32'h80); settle();
    chk("R8 edge req follows raw", 64'(irq_req[7]), 64'h0);
    @(negedge clk); irq_in[7] = 1'b1; settle();
    wr(6'h04, 32'h80);
    @(negedge clk); irq_in[7] = 1'b0; settle();
    rd(6'h04, d); chk("R5 falling edge ignored in rise mode", 64'(d), 64'h0);
    cleanup();
  endtask

  task automatic t_fall();
    logic [31:0] d;
    wr(6'h18, 32'h200); settle();
    @(negedge clk); irq_in[9] = 1'b1; settle();
    rd(6'h04, d); chk("R4 rising ignored in fall mode", 64'(d), 64'h0);
    @(negedge clk); irq_in[9] = 1'b0; settle();
    rd(6'h04, d); chk("R4 falling captured", 64'(d), 64'h200);
    chk("R8 fall request", 64'(irq_req[9]), 64'h1);
    wr(6'h04, 32'h0); rd(6'h04, d); chk("R6 zero ack no effect", 64'(d), 64'h200);
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, d); chk("R6 all-ones ack", 64'(d), 64'h0);
    cleanup();
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(6'h10, 32'h10); settle();
    @(negedge clk); irq_in[4] = 1'b1; settle();
    @(negedge clk); irq_in[4] = 1'b0; settle();
    @(negedge clk); irq_in[4] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 6'h04; reg_wdata = 32'h10;
    @(posedge clk); @(negedge clk); reg_wr = 1'b0;
    settle();
    rd(6'h04, d); chk("R7 edge beats ack", 64'(d), 64'h10);
    wr(6'h04, 32'h10); rd(6'h04, d); chk("R7 plain ack clears", 64'(d), 64'h0);
    cleanup();
  endtask

  task automatic t_high();
    logic [31:0] d;
    wr(6'h30, 32'h100);
    rd(6'h28, d); chk("R2 high bank rise cfg", 64'(d), 64'h100);
    rd(6'h08, d); chk("R2 low bank untouched", 64'(d), 64'h0);
    @(negedge clk); irq_in[40] = 1'b1; settle();
    irq_in[40] = 1'b0; settle();
    rd(6'h24, d); chk("R2 high bank raw", 64'(d), 64'h100);
    rd(6'h04, d); chk("R2 low bank raw clean", 64'(d), 64'h0);
    rd(6'h20, d); chk("R2 high bank status", 64'(d), 64'h100);
    chk("R2 line 40 request", irq_req, 64'h1 << 40);
    cleanup();
  endtask

  initial begin
    rst = 1'b1; irq_in = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_level();
    t_rise();
    t_fall();
    t_collide();
    t_high();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule